// File: doc/BRIEF.md
# Display Enable Timing Generator

This block produces horizontal sync, vertical sync and a display-enable strobe for a bitmap video path. A horizontal counter runs at the CPU clock rate and a vertical line counter advances at the end of every line. Two tiny CPU-written registers steer the geometry: a refresh-rate register (50 Hz or 60 Hz) and a resolution register (low, medium or high).

The rate is not frozen per frame. It is consulted at fixed decision points: when a line wraps, when display-enable may start or stop inside a line, and when a frame reaches its first or last display line. Software that flips the rate at the right cycle can move the display-enable edges, leave a line dark, or keep display-enable running past the normal last line so that the lower border opens. The stored register bits go out unchanged to the pixel path.

Top module: `video_timing_gen`

## Requirements
- R1: A low/medium-resolution line lasts P50_LEN cycles (default 512) when the rate register selects 50 Hz at the line wrap, and P60_LEN cycles (default 508) when it selects 60 Hz; the length is fixed at the wrap cycle for the whole following line.
- R2: A write stores only data bits [1:0] in the register picked by wr_sel_i (0 = rate, 1 = resolution) and leaves the other register alone. Rate bit 1 = 1 means 50 Hz and 0 means 60 Hz. Resolution values 2 and 3 mean high resolution.
- R3: A write lands only on even cycles: the first rising edge after reset release is cycle 0 and is even. A write offered on an odd cycle is dropped.
- R4: Display-enable rises at H_START_60 (default 52) if the rate reads 60 Hz at that cycle, or at H_START_50 (default 56) if it reads 50 Hz there. A line that sees neither stays dark.
- R5: Display-enable falls at H_END_50 (default 376). If the rate reads 60 Hz when the count reaches H_END_60 (default 372), it falls there instead, 4 cycles earlier.
- R6: Lines are eligible for display from V_FIRST_60 (34) or V_FIRST_50 (63), and stop before V_LAST_60 (234) or V_LAST_50 (263). Each line number acts only when the rate at the wrap into that line matches.
- R7: If the rate reads 60 Hz at the wrap into V_LAST_50, vertical display stays on until the frame ends (lower border opened).
- R8: Frame length is F50_LINES (313), F60_LINES (263) or FHI_LINES (501), chosen at the wrap into line 0 from the mode at that cycle.
- R9: de_o is low on every line outside the vertical display window, and line 0 is never displayed.
- R10: hsync_o is high on the last HS_LEN (40) cycles of each low/medium line, and on the last HS_LEN_HI (16) cycles in high resolution.
- R11: vsync_o is high on the last VS_LINES (3) lines of each frame.
- R12: In high resolution the rate bit is ignored: lines last PHI_LEN (224), display-enable covers H_START_HI to H_END_HI-1 (4 to 163), and display lines run from V_FIRST_HI to V_LAST_HI-1.
- R13: During reset, de_o, hsync_o and vsync_o are low, the rate register reads 2'b10 (50 Hz) and the resolution register reads 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = rate register, 1 = resolution register |
| wr_data_i | input | DATA_W | Write data; only bits [1:0] are kept |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| sync_mode_o | output | 2 | Stored rate register |
| res_mode_o | output | 2 | Stored resolution register |

## Verification
A wrong horizontal count or line length shows up within one line as a de_o or hsync_o edge that lands on the wrong cycle. It then drifts further on every following line. A wrong vertical decision state shows up as a whole line of de_o that is present or missing, one line after the faulty wrap. It also shows up as a lower border that opens or closes wrongly before the frame ends. A frame length latched wrongly moves vsync_o by whole lines in the next frame. The directed scenarios sample these ports at the exact cycles where the decision points act.

// File: rtl/vt_pkg.sv
package vt_pkg;

  typedef enum logic {
    SEL_RATE = 1'b0,
    SEL_RES  = 1'b1
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_50 = 2'd0,
    MODE_60 = 2'd1,
    MODE_HI = 2'd2
  } scan_mode_e;

  localparam logic [1:0] RATE_RESET = 2'b10;
  localparam logic [1:0] RES_RESET  = 2'b00;

  function automatic scan_mode_e mode_of(input logic rate50, input logic hi);
    if (hi)          return MODE_HI;
    else if (rate50) return MODE_50;
    else             return MODE_60;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/vt_regs.sv
module vt_regs
  import vt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              even_i,
  output logic [1:0]        rate_o,
  output logic [1:0]        res_o
);

  logic [1:0] rate_q, res_q;
  logic       take;
  logic       unused_hi;

  assign take      = wr_en_i & even_i;
  assign unused_hi = ^wr_data_i[DATA_W-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= RATE_RESET;
      res_q  <= RES_RESET;
    end else if (take) begin
      if (reg_sel_e'(wr_sel_i) == SEL_RES) res_q  <= wr_data_i[1:0];
      else                                 rate_q <= wr_data_i[1:0];
    end
  end

  assign rate_o = rate_q;
  assign res_o  = res_q;

  p_odd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !even_i |=> ($stable(rate_q) && $stable(res_q)));

  p_sel_isolation_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> $stable(rate_q));

endmodule

// File: rtl/vt_hgen.sv
module vt_hgen
  import vt_pkg::*;
#(
  parameter int P50_LEN    = 512,
  parameter int P60_LEN    = 508,
  parameter int PHI_LEN    = 224,
  parameter int H_START_60 = 52,
  parameter int H_START_50 = 56,
  parameter int H_END_60   = 372,
  parameter int H_END_50   = 376,
  parameter int H_START_HI = 4,
  parameter int H_END_HI   = 164,
  parameter int HS_LEN     = 40,
  parameter int HS_LEN_HI  = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  scan_mode_e mode_i,
  output logic       line_end_o,
  output logic       win_nxt_o,
  output logic       hsync_o,
  output logic       even_o
);

  localparam int HMAX = max3(P50_LEN, P60_LEN, PHI_LEN);
  localparam int PW   = $clog2(HMAX + 1);
  typedef logic [PW-1:0] hcnt_t;

  hcnt_t h_q, h_nxt, period_q, period_eff, period_new, hs_from;
  logic  win_q, win_nxt, hs_nxt, h_last, start_hit, end_hit;

  always_comb begin
    unique case (mode_i)
      MODE_60: period_new = hcnt_t'(P60_LEN);
      MODE_HI: period_new = hcnt_t'(PHI_LEN);
      default: period_new = hcnt_t'(P50_LEN);
    endcase
  end

  assign h_last     = (h_q == period_q - hcnt_t'(1));
  assign h_nxt      = h_last ? '0 : h_q + hcnt_t'(1);
  assign period_eff = h_last ? period_new : period_q;

  // start/end decisions sample the mode on the edge that enters the position
  always_comb begin
    start_hit = 1'b0;
    end_hit   = 1'b0;
    unique case (mode_i)
      MODE_50: begin
        start_hit = (h_nxt == hcnt_t'(H_START_50));
        end_hit   = (h_nxt == hcnt_t'(H_END_50));
      end
      MODE_60: begin
        start_hit = (h_nxt == hcnt_t'(H_START_60));
        end_hit   = (h_nxt == hcnt_t'(H_END_60)) || (h_nxt == hcnt_t'(H_END_50));
      end
      default: begin
        start_hit = (h_nxt == hcnt_t'(H_START_HI));
        end_hit   = (h_nxt == hcnt_t'(H_END_HI));
      end
    endcase
  end

  always_comb begin
    if (h_last)         win_nxt = 1'b0;
    else if (start_hit) win_nxt = 1'b1;
    else if (end_hit)   win_nxt = 1'b0;
    else                win_nxt = win_q;
  end

  assign hs_from = period_eff - ((mode_i == MODE_HI) ? hcnt_t'(HS_LEN_HI) : hcnt_t'(HS_LEN));
  assign hs_nxt  = (h_nxt >= hs_from);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q      <= '0;
      period_q <= hcnt_t'(P50_LEN);
      win_q    <= 1'b0;
      hsync_o  <= 1'b0;
    end else begin
      h_q      <= h_nxt;
      period_q <= period_eff;
      win_q    <= win_nxt;
      hsync_o  <= hs_nxt;
    end
  end

  assign line_end_o = h_last;
  assign win_nxt_o  = win_nxt;
  assign even_o     = ~h_q[0];

  p_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_last && mode_i == MODE_50) |=> (period_q == hcnt_t'(P50_LEN)));

  p_early_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_60 && h_nxt == hcnt_t'(H_END_60)) |=> !win_q);

  p_hs_tail_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_last |-> hsync_o);

endmodule

// File: rtl/vt_vgen.sv
module vt_vgen
  import vt_pkg::*;
#(
  parameter int F50_LINES  = 313,
  parameter int F60_LINES  = 263,
  parameter int FHI_LINES  = 501,
  parameter int V_FIRST_60 = 34,
  parameter int V_FIRST_50 = 63,
  parameter int V_LAST_60  = 234,
  parameter int V_LAST_50  = 263,
  parameter int V_FIRST_HI = 34,
  parameter int V_LAST_HI  = 434,
  parameter int VS_LINES   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  scan_mode_e mode_i,
  input  logic       adv_i,
  output logic       vde_nxt_o,
  output logic       vde_o,
  output logic       vsync_o
);

  localparam int VMAX = max3(F50_LINES, F60_LINES, FHI_LINES);
  localparam int VW   = $clog2(VMAX + 1);
  typedef logic [VW-1:0] vcnt_t;

  vcnt_t v_q, v_nxt, frame_q, frame_new, frame_eff;
  logic  vde_q, vde_nxt, v_last, wrap, first_hit, last_hit, vs_nxt;

  always_comb begin
    unique case (mode_i)
      MODE_60: frame_new = vcnt_t'(F60_LINES);
      MODE_HI: frame_new = vcnt_t'(FHI_LINES);
      default: frame_new = vcnt_t'(F50_LINES);
    endcase
  end

  assign v_last    = (v_q == frame_q - vcnt_t'(1));
  assign wrap      = adv_i & v_last;
  assign v_nxt     = !adv_i ? v_q : (v_last ? '0 : v_q + vcnt_t'(1));
  assign frame_eff = wrap ? frame_new : frame_q;

  always_comb begin
    first_hit = 1'b0;
    last_hit  = 1'b0;
    unique case (mode_i)
      MODE_50: begin
        first_hit = (v_nxt == vcnt_t'(V_FIRST_50));
        last_hit  = (v_nxt == vcnt_t'(V_LAST_50));
      end
      MODE_60: begin
        // no stop at the 50 Hz last line: lower border stays open
        first_hit = (v_nxt == vcnt_t'(V_FIRST_60));
        last_hit  = (v_nxt == vcnt_t'(V_LAST_60));
      end
      default: begin
        first_hit = (v_nxt == vcnt_t'(V_FIRST_HI));
        last_hit  = (v_nxt == vcnt_t'(V_LAST_HI));
      end
    endcase
  end

  always_comb begin
    if (!adv_i)          vde_nxt = vde_q;
    else if (v_nxt == 0) vde_nxt = 1'b0;
    else if (first_hit)  vde_nxt = 1'b1;
    else if (last_hit)   vde_nxt = 1'b0;
    else                 vde_nxt = vde_q;
  end

  assign vs_nxt = (v_nxt >= frame_eff - vcnt_t'(VS_LINES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q     <= '0;
      frame_q <= vcnt_t'(F50_LINES);
      vde_q   <= 1'b0;
      vsync_o <= 1'b0;
    end else begin
      v_q     <= v_nxt;
      frame_q <= frame_eff;
      vde_q   <= vde_nxt;
      vsync_o <= vs_nxt;
    end
  end

  assign vde_nxt_o = vde_nxt;
  assign vde_o     = vde_q;

  p_frame_dark_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> !vde_q);

  p_border_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && mode_i == MODE_60 && v_nxt == vcnt_t'(V_LAST_50) && vde_q
     && v_nxt != vcnt_t'(V_LAST_60)) |=> vde_q);

  p_frame_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && mode_i == MODE_60) |=> (frame_q == vcnt_t'(F60_LINES)));

endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vt_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int P50_LEN    = 512,
  parameter int P60_LEN    = 508,
  parameter int PHI_LEN    = 224,
  parameter int H_START_60 = 52,
  parameter int H_START_50 = 56,
  parameter int H_END_60   = 372,
  parameter int H_END_50   = 376,
  parameter int H_START_HI = 4,
  parameter int H_END_HI   = 164,
  parameter int HS_LEN     = 40,
  parameter int HS_LEN_HI  = 16,
  parameter int F50_LINES  = 313,
  parameter int F60_LINES  = 263,
  parameter int FHI_LINES  = 501,
  parameter int V_FIRST_60 = 34,
  parameter int V_FIRST_50 = 63,
  parameter int V_LAST_60  = 234,
  parameter int V_LAST_50  = 263,
  parameter int V_FIRST_HI = 34,
  parameter int V_LAST_HI  = 434,
  parameter int VS_LINES   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [1:0]        sync_mode_o,
  output logic [1:0]        res_mode_o
);

  logic [1:0] rate_q, res_q;
  scan_mode_e mode;
  logic       even, line_end, win_nxt, vde_nxt, vde_q, de_q;

  assign mode = mode_of(rate_q[1], res_q[1]);

  vt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .even_i   (even),
    .rate_o   (rate_q),
    .res_o    (res_q)
  );

  vt_hgen #(
    .P50_LEN(P50_LEN), .P60_LEN(P60_LEN), .PHI_LEN(PHI_LEN),
    .H_START_60(H_START_60), .H_START_50(H_START_50),
    .H_END_60(H_END_60), .H_END_50(H_END_50),
    .H_START_HI(H_START_HI), .H_END_HI(H_END_HI),
    .HS_LEN(HS_LEN), .HS_LEN_HI(HS_LEN_HI)
  ) u_hgen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .line_end_o(line_end),
    .win_nxt_o (win_nxt),
    .hsync_o   (hsync_o),
    .even_o    (even)
  );

  vt_vgen #(
    .F50_LINES(F50_LINES), .F60_LINES(F60_LINES), .FHI_LINES(FHI_LINES),
    .V_FIRST_60(V_FIRST_60), .V_FIRST_50(V_FIRST_50),
    .V_LAST_60(V_LAST_60), .V_LAST_50(V_LAST_50),
    .V_FIRST_HI(V_FIRST_HI), .V_LAST_HI(V_LAST_HI),
    .VS_LINES(VS_LINES)
  ) u_vgen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .adv_i    (line_end),
    .vde_nxt_o(vde_nxt),
    .vde_o    (vde_q),
    .vsync_o  (vsync_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) de_q <= 1'b0;
    else         de_q <= win_nxt & vde_nxt;
  end

  assign de_o        = de_q;
  assign sync_mode_o = rate_q;
  assign res_mode_o  = res_q;

  p_de_window_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> vde_q);

endmodule

// File: tb/video_timing_gen_test.sv
module video_timing_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        hs, vs, de;
  logic [1:0]  sync_m, res_m;

  int checks = 0;
  int failures = 0;
  int edges = 0;

  always #4 clk = ~clk;

  // reduced geometry keeps every scenario short
  video_timing_gen #(
    .DATA_W(16), .P50_LEN(64), .P60_LEN(60), .PHI_LEN(32),
    .H_START_60(8), .H_START_50(12), .H_END_60(44), .H_END_50(48),
    .H_START_HI(4), .H_END_HI(24), .HS_LEN(6), .HS_LEN_HI(4),
    .F50_LINES(20), .F60_LINES(16), .FHI_LINES(24),
    .V_FIRST_60(2), .V_FIRST_50(4), .V_LAST_60(12), .V_LAST_50(14),
    .V_FIRST_HI(1), .V_LAST_HI(20), .VS_LINES(2)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .hsync_o(hs), .vsync_o(vs), .de_o(de),
    .sync_mode_o(sync_m), .res_mode_o(res_m)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;

  typedef struct packed {
    logic        sel;
    logic [15:0] data;
    logic        odd;
    logic [1:0]  exp_rate;
    logic [1:0]  exp_res;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 16'hFFFC, 1'b0, 2'b00, 2'b00},
    '{1'b0, 16'h0003, 1'b0, 2'b11, 2'b00},
    '{1'b1, 16'hABCE, 1'b0, 2'b11, 2'b10},
    '{1'b1, 16'h5551, 1'b1, 2'b11, 2'b10},
    '{1'b0, 16'h0000, 1'b1, 2'b11, 2'b10},
    '{1'b1, 16'h8001, 1'b0, 2'b11, 2'b01},
    '{1'b0, 16'h7FFE, 1'b0, 2'b10, 2'b01},
    '{1'b1, 16'hFFF0, 1'b0, 2'b10, 2'b00}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at edge %0d: actual=%0h expected=%0h", req, edges, act, exp);
    end
  endtask

  task automatic at_edge(input int n);
    while (edges < n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // write lands on edge n when that edge is even in cycle terms (n odd)
  task automatic write_at(input int n, input logic sel, input logic [15:0] d);
    at_edge(n - 1);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    at_edge(n);
    wr_en = 1'b0;
  endtask

  task automatic expect_de(input int n, input logic v, input string req);
    at_edge(n); check(req, {15'b0, de}, {15'b0, v});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R13 reset state
    @(negedge clk); @(negedge clk);
    check("R13 de", {15'b0, de}, 16'h0);
    check("R13 hs", {15'b0, hs}, 16'h0);
    check("R13 vs", {15'b0, vs}, 16'h0);
    check("R13 rate", {14'b0, sync_m}, 16'h2);
    check("R13 res", {14'b0, res_m}, 16'h0);
    rst_n = 1'b1;

    // R2 / R3 register vectors
    for (int i = 0; i < 8; i++) begin
      int n;
      n = edges + 2;
      if ((n % 2 == 1) == VECS[i].odd) n++;
      write_at(n, VECS[i].sel, VECS[i].data);
      check(VECS[i].odd ? "R3 rate" : "R2 rate", {14'b0, sync_m}, {14'b0, VECS[i].exp_rate});
      check(VECS[i].odd ? "R3 res" : "R2 res", {14'b0, res_m}, {14'b0, VECS[i].exp_res});
    end

    // 50 Hz frame
    do_reset();
    at_edge(57);  check("R10 hs off", {15'b0, hs}, 16'h0);
    at_edge(58);  check("R10 hs on", {15'b0, hs}, 16'h1);
    expect_de(212, 1'b0, "R9 above window");
    expect_de(267, 1'b0, "R4 before 50 start");
    expect_de(268, 1'b1, "R4 50 start");
    expect_de(303, 1'b1, "R5 50 last");
    expect_de(304, 1'b0, "R5 50 end");
    expect_de(916, 1'b0, "R6 50 last line");
    at_edge(1151); check("R11 vs off", {15'b0, vs}, 16'h0);
    at_edge(1152); check("R11 vs on", {15'b0, vs}, 16'h1);

    // 60 Hz
    do_reset();
    write_at(1, 1'b0, 16'h0000);
    at_edge(117); check("R10 60 hs off", {15'b0, hs}, 16'h0);
    at_edge(118); check("R10 60 hs on", {15'b0, hs}, 16'h1);
    expect_de(131, 1'b0, "R1 60 line before start");
    expect_de(132, 1'b1, "R4 60 start");
    expect_de(167, 1'b1, "R5 60 last");
    expect_de(168, 1'b0, "R5 60 end");
    expect_de(684, 1'b1, "R6 60 line 11");
    expect_de(744, 1'b0, "R6 60 line 12");
    at_edge(1083); check("R11 f0 vs off", {15'b0, vs}, 16'h0);
    at_edge(1084); check("R11 f0 vs on", {15'b0, vs}, 16'h1);
    at_edge(2043); check("R8 f1 vs off", {15'b0, vs}, 16'h0);
    at_edge(2044); check("R8 f1 vs on", {15'b0, vs}, 16'h1);
    at_edge(2164); check("R8 f1 wrap", {15'b0, vs}, 16'h0);

    // R7 lower border
    do_reset();
    write_at(881, 1'b0, 16'h0000);
    write_at(897, 1'b0, 16'h0002);
    expect_de(916, 1'b1, "R7 line 14");
    expect_de(976, 1'b1, "R7 line 15");
    expect_de(1232, 1'b1, "R7 line 19");
    at_edge(1148); check("R11 border vs", {15'b0, vs}, 16'h1);
    expect_de(1296, 1'b0, "R9 next frame line 0");

    // R4 missed start
    do_reset();
    write_at(265, 1'b0, 16'h0000);
    expect_de(276, 1'b0, "R4 missed start");
    write_at(277, 1'b0, 16'h0002);
    expect_de(340, 1'b1, "R4 next line normal");

    // R5 early drop mid-line
    do_reset();
    write_at(361, 1'b0, 16'h0000);
    expect_de(363, 1'b1, "R5 before early drop");
    expect_de(364, 1'b0, "R5 early drop");

    // R12 high resolution
    do_reset();
    write_at(1, 1'b1, 16'h0002);
    expect_de(67, 1'b0, "R12 before start");
    expect_de(68, 1'b1, "R12 start");
    expect_de(87, 1'b1, "R12 last");
    expect_de(88, 1'b0, "R12 end");
    at_edge(91); check("R12 hs off", {15'b0, hs}, 16'h0);
    at_edge(92); check("R12 hs on", {15'b0, hs}, 16'h1);
    expect_de(100, 1'b1, "R12 R1 short line");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule